// File: doc/BRIEF.md
# Preset Up/Down Event Counter

This block counts discrete events arriving on two level inputs, one that adds and one that subtracts. Each input is sampled once per clock, and a step happens only on the cycle where that input is seen going from low to high. A held level counts once. The running value can be forced to zero by a clear input or to a caller-supplied preset by a load input. It never wraps: at either end of its numeric range it saturates.

Two flags compare the running value against thresholds. One is raised when the value has reached or passed the preset. The other is raised when the value is at or below zero. A parameter fixes the width (8, 16 or 32 bits are the intended choices). A second parameter chooses unsigned or two's-complement interpretation, and that choice governs both the saturation bounds and the comparisons. The asynchronous active-low reset is synchronised internally before release.

Top module: `updown_event_counter`

## Requirements
- R1: While `rst_n` is low, and until the internal reset has been released, `count` is 0 and no event is counted.
- R2: When `clr` is 1 at a clock edge, `count` becomes 0 on that edge. This overrides `ld` and any event.
- R3: When `ld` is 1 and `clr` is 0 at an edge, `count` takes the value of `preset` on that edge. This overrides any event.
- R4: With `clr` and `ld` low, `up_evt` sampled 1 after being sampled 0 on the previous edge (and `dn_evt` not rising) adds exactly one to `count`. Holding `up_evt` at 1 gives no further steps.
- R5: With `clr` and `ld` low, a rise of `dn_evt` alone subtracts exactly one from `count`.
- R6: If `up_evt` and `dn_evt` rise on the same edge, `count` keeps its value.
- R7: With `SIGNED_MODE`=0, `count` saturates at 0 when counting down and at 2^WIDTH-1 when counting up.
- R8: With `SIGNED_MODE`=1, `count` is two's complement and saturates at -2^(WIDTH-1) and at 2^(WIDTH-1)-1.
- R9: `at_preset` is 1 exactly when `count` >= `preset`. The comparison is combinational on both inputs and is signed when `SIGNED_MODE`=1.
- R10: `at_floor` is 1 exactly when `count` <= 0. That means `count`==0 in unsigned mode, and zero or negative in signed mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| up_evt | input | 1 | Count-up event line; acts on a sampled rise |
| dn_evt | input | 1 | Count-down event line; acts on a sampled rise |
| clr | input | 1 | Force count to zero (highest priority) |
| ld | input | 1 | Load preset into count |
| preset | input | WIDTH | Preset value, also the upper comparison threshold |
| count | output | WIDTH | Current count value |
| at_preset | output | 1 | count at or above preset |
| at_floor | output | 1 | count at or below zero |

## Verification
The saturation points are the hardest states to reach from the ports. Each step needs a low-then-high pair of samples, so reaching a bound at 8 bits takes hundreds of cycles of alternating input. Pressing past the bound takes more. The stimulus drives long directed pulse trains upward and then downward through both bounds, on an unsigned and a signed instance side by side. It then mixes loads of extreme preset values into seeded random traffic, so the bounds are revisited with clears, loads and simultaneous rises landing on them.

// File: rtl/updown_counter_pkg.sv
package updown_counter_pkg;

  // Action selected for the count register in one cycle
  typedef enum logic [2:0] {
    ACT_HOLD  = 3'd0,
    ACT_CLEAR = 3'd1,
    ACT_LOAD  = 3'd2,
    ACT_INC   = 3'd3,
    ACT_DEC   = 3'd4
  } cnt_act_e;

endpackage

// File: rtl/uc_rise_detect.sv
// Per-bit rising-edge detector against a stored copy of the previous sample
module uc_rise_detect #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] sig_in,
  output logic [LANES-1:0] rise
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic prev_q;
    logic prev_d;

    always_comb begin
      prev_d = sig_in[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
      end else begin
        prev_q <= prev_d;
      end
    end

    assign rise[g] = sig_in[g] & ~prev_q;
  end

endmodule

// File: rtl/uc_action_sel.sv
// Priority: clear, then load, then a single event direction
module uc_action_sel
  import updown_counter_pkg::*;
(
  input  logic     clr,
  input  logic     ld,
  input  logic     rise_up,
  input  logic     rise_dn,
  output cnt_act_e act
);

  always_comb begin
    if (clr) begin
      act = ACT_CLEAR;
    end else if (ld) begin
      act = ACT_LOAD;
    end else begin
      unique case ({rise_up, rise_dn})
        2'b10:   act = ACT_INC;
        2'b01:   act = ACT_DEC;
        default: act = ACT_HOLD;
      endcase
    end
  end

endmodule

// File: rtl/uc_sat_step.sv
// Next-value computation with saturation at the interpretation's bounds
module uc_sat_step
  import updown_counter_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter bit SIGNED_MODE = 1'b0
) (
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] preset,
  input  cnt_act_e         act,
  output logic [WIDTH-1:0] nxt
);

  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] hi_bound;
  logic [WIDTH-1:0] lo_bound;

  if (SIGNED_MODE) begin : g_signed_bounds
    assign hi_bound = {1'b0, {(WIDTH-1){1'b1}}};
    assign lo_bound = {1'b1, {(WIDTH-1){1'b0}}};
  end else begin : g_unsigned_bounds
    assign hi_bound = {WIDTH{1'b1}};
    assign lo_bound = {WIDTH{1'b0}};
  end

  logic at_hi;
  logic at_lo;

  assign at_hi = (cur == hi_bound);
  assign at_lo = (cur == lo_bound);

  always_comb begin
    nxt = cur;
    unique case (act)
      ACT_CLEAR: nxt = '0;
      ACT_LOAD:  nxt = preset;
      ACT_INC:   nxt = at_hi ? cur : cur + ONE;
      ACT_DEC:   nxt = at_lo ? cur : cur - ONE;
      default:   nxt = cur;
    endcase
  end

endmodule

// File: rtl/uc_flags.sv
// Threshold comparisons of the count against the preset and against zero
module uc_flags #(
  parameter int WIDTH       = 16,
  parameter bit SIGNED_MODE = 1'b0
) (
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] preset,
  output logic             ge_preset,
  output logic             le_zero
);

  localparam int MSB = WIDTH - 1;

  logic is_zero;
  assign is_zero = ~|cur;

  if (SIGNED_MODE) begin : g_signed_cmp
    assign ge_preset = ($signed(cur) >= $signed(preset));
    assign le_zero   = cur[MSB] | is_zero;
  end else begin : g_unsigned_cmp
    assign ge_preset = (cur >= preset);
    assign le_zero   = is_zero;
  end

endmodule

// File: rtl/updown_event_counter.sv
module updown_event_counter
  import updown_counter_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter bit SIGNED_MODE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_evt,
  input  logic             dn_evt,
  input  logic             clr,
  input  logic             ld,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] count,
  output logic             at_preset,
  output logic             at_floor
);

  localparam int SYNC_STAGES = 2;
  localparam int LANES       = 2;

  // Reset: asserted asynchronously, released through a flop chain
  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe_q[SYNC_STAGES-1];

  // Event edge detection
  logic [LANES-1:0] evt_rise;

  uc_rise_detect #(
    .LANES (LANES)
  ) u_rise (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .sig_in ({dn_evt, up_evt}),
    .rise   (evt_rise)
  );

  // Action arbitration
  cnt_act_e act;

  uc_action_sel u_sel (
    .clr     (clr),
    .ld      (ld),
    .rise_up (evt_rise[0]),
    .rise_dn (evt_rise[1]),
    .act     (act)
  );

  // Next value
  logic [WIDTH-1:0] count_q;
  logic [WIDTH-1:0] count_d;
  logic             count_en;

  uc_sat_step #(
    .WIDTH       (WIDTH),
    .SIGNED_MODE (SIGNED_MODE)
  ) u_step (
    .cur    (count_q),
    .preset (preset),
    .act    (act),
    .nxt    (count_d)
  );

  assign count_en = (act != ACT_HOLD);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

  assign count = count_q;

  // Threshold flags
  uc_flags #(
    .WIDTH       (WIDTH),
    .SIGNED_MODE (SIGNED_MODE)
  ) u_flags (
    .cur       (count_q),
    .preset    (preset),
    .ge_preset (at_preset),
    .le_zero   (at_floor)
  );

endmodule

// File: rtl/uc_counter_checks.sv
module uc_counter_checks #(
  parameter int WIDTH       = 16,
  parameter bit SIGNED_MODE = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_sync_n,
  input logic             up_evt,
  input logic             dn_evt,
  input logic             clr,
  input logic             ld,
  input logic [WIDTH-1:0] preset,
  input logic [WIDTH-1:0] count,
  input logic             at_preset,
  input logic             at_floor
);

  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] HI  = SIGNED_MODE ? {1'b0, {(WIDTH-1){1'b1}}} : {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] LO  = SIGNED_MODE ? {1'b1, {(WIDTH-1){1'b0}}} : {WIDTH{1'b0}};

  // R1: held reset keeps the count at zero
  always @(negedge clk) begin
    if (!rst_n) begin
      a_reset_zero_r1: assert (count == '0);
    end
  end

  // R2
  p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clr |=> (count == '0));

  // R10: clearing lands on the floor flag
  p_clear_floor_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clr |=> at_floor);

  // R3
  p_load_value_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!clr && ld) |=> (count == $past(preset)));

  // R9: after a load with an unchanged preset the preset flag is up
  p_load_reaches_preset_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!clr && ld) |=> (!$stable(preset) || at_preset));

  // R4 / R5: without clear or load the count moves by at most one
  p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!clr && !ld) |=> (count == $past(count) ||
                       count == $past(count) + ONE ||
                       count == $past(count) - ONE));

  // R4: low event lines cannot change the count
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!clr && !ld && !up_evt && !dn_evt) |=> $stable(count));

  if (SIGNED_MODE) begin : g_sat_signed
    // R8
    p_no_wrap_low_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (count == LO && !ld) |=> (count != HI));
    p_no_wrap_high_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (count == HI && !ld && !clr) |=> (count != LO));
  end else begin : g_sat_unsigned
    // R7
    p_no_wrap_low_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (count == LO && !ld) |=> (count != HI));
    p_no_wrap_high_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (count == HI && !ld && !clr) |=> (count != LO));
  end

endmodule

bind updown_event_counter uc_counter_checks #(
  .WIDTH       (WIDTH),
  .SIGNED_MODE (SIGNED_MODE)
) u_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .up_evt     (up_evt),
  .dn_evt     (dn_evt),
  .clr        (clr),
  .ld         (ld),
  .preset     (preset),
  .count      (count),
  .at_preset  (at_preset),
  .at_floor   (at_floor)
);

// File: tb/updown_event_counter_test.sv
module updown_event_counter_test;

  localparam int W = 8;

  logic         clk;
  logic         rst_n;
  logic         up_evt, dn_evt, clr, ld;
  logic [W-1:0] preset;
  logic [W-1:0] cnt_u, cnt_s;
  logic         pre_u, pre_s, flr_u, flr_s;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done     = 0;

  // model state
  logic [W-1:0] m_u, m_s;
  logic         m_prev_up, m_prev_dn;
  string        m_tag_u, m_tag_s;

  updown_event_counter #(.WIDTH(W), .SIGNED_MODE(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .up_evt(up_evt), .dn_evt(dn_evt),
    .clr(clr), .ld(ld), .preset(preset),
    .count(cnt_u), .at_preset(pre_u), .at_floor(flr_u)
  );

  updown_event_counter #(.WIDTH(W), .SIGNED_MODE(1'b1)) uut_sgn (
    .clk(clk), .rst_n(rst_n), .up_evt(up_evt), .dn_evt(dn_evt),
    .clr(clr), .ld(ld), .preset(preset),
    .count(cnt_s), .at_preset(pre_s), .at_floor(flr_s)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [W-1:0] hi_of(input bit sg);
    return sg ? 8'h7f : 8'hff;
  endfunction

  function automatic logic [W-1:0] lo_of(input bit sg);
    return sg ? 8'h80 : 8'h00;
  endfunction

  function automatic logic [W-1:0] model_next(input logic [W-1:0] cur, input bit sg,
      input bit ru, input bit rd, input bit c, input bit l, input logic [W-1:0] p);
    if (c) return '0;
    if (l) return p;
    if (ru && !rd) return (cur == hi_of(sg)) ? cur : cur + 8'd1;
    if (rd && !ru) return (cur == lo_of(sg)) ? cur : cur - 8'd1;
    return cur;
  endfunction

  function automatic string model_tag(input logic [W-1:0] cur, input bit sg,
      input bit ru, input bit rd, input bit c, input bit l);
    if (c) return "R2";
    if (l) return "R3";
    if (ru && rd) return "R6";
    if (ru && cur == hi_of(sg)) return sg ? "R8" : "R7";
    if (rd && cur == lo_of(sg)) return sg ? "R8" : "R7";
    if (rd) return "R5";
    return "R4";
  endfunction

  function automatic bit model_ge(input logic [W-1:0] cur, input logic [W-1:0] p, input bit sg);
    if (sg) return $signed(cur) >= $signed(p);
    return cur >= p;
  endfunction

  function automatic bit model_le0(input logic [W-1:0] cur, input bit sg);
    if (sg) return $signed(cur) <= 0;
    return cur == 0;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Called at a negedge: drive, let one posedge pass, check at the next negedge
  task automatic step(input bit u, input bit d, input bit c, input bit l, input logic [W-1:0] p);
    bit ru, rd;
    up_evt = u; dn_evt = d; clr = c; ld = l; preset = p;
    ru = u && !m_prev_up;
    rd = d && !m_prev_dn;
    m_tag_u = model_tag(m_u, 1'b0, ru, rd, c, l);
    m_tag_s = model_tag(m_s, 1'b1, ru, rd, c, l);
    m_u = model_next(m_u, 1'b0, ru, rd, c, l, p);
    m_s = model_next(m_s, 1'b1, ru, rd, c, l, p);
    m_prev_up = u;
    m_prev_dn = d;
    @(posedge clk);
    @(negedge clk);
    check(m_tag_u, "unsigned count", cnt_u, m_u);
    check(m_tag_s, "signed count",   cnt_s, m_s);
    check("R9",  "unsigned at_preset", pre_u, model_ge(m_u, p, 1'b0));
    check("R9",  "signed at_preset",   pre_s, model_ge(m_s, p, 1'b1));
    check("R10", "unsigned at_floor",  flr_u, model_le0(m_u, 1'b0));
    check("R10", "signed at_floor",    flr_s, model_le0(m_s, 1'b1));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin : stimulus
    logic [W-1:0] extremes [4];
    extremes[0] = 8'h00; extremes[1] = 8'hff; extremes[2] = 8'h7f; extremes[3] = 8'h80;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; up_evt = 0; dn_evt = 0; clr = 0; ld = 0; preset = 8'd10;
    m_u = '0; m_s = '0; m_prev_up = 0; m_prev_dn = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "unsigned count in reset", cnt_u, 0);
    check("R1", "signed count in reset",   cnt_s, 0);
    rst_n = 1'b1;
    // R1: pulses during the synchronised release are not counted
    up_evt = 1'b1;
    @(negedge clk);
    up_evt = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "unsigned count after release", cnt_u, 0);
    check("R1", "signed count after release",   cnt_s, 0);

    // R4: a held level counts once
    step(1, 0, 0, 0, 8'd3);
    step(1, 0, 0, 0, 8'd3);
    step(1, 0, 0, 0, 8'd3);
    step(0, 0, 0, 0, 8'd3);
    // R4/R7/R8: climb through both upper bounds
    for (int i = 0; i < 270; i++) begin
      step(1, 0, 0, 0, 8'd200);
      step(0, 0, 0, 0, 8'd200);
    end
    // R6: simultaneous rises at the bound
    step(1, 1, 0, 0, 8'd200);
    step(0, 0, 0, 0, 8'd200);
    // R5/R7/R8: descend through both lower bounds
    for (int i = 0; i < 270; i++) begin
      step(0, 1, 0, 0, 8'd5);
      step(0, 0, 0, 0, 8'd5);
    end
    // R2 over R3 over events
    step(1, 0, 1, 1, 8'h55);
    step(0, 0, 0, 0, 8'h55);
    step(1, 0, 0, 1, 8'h7f);
    step(0, 0, 0, 0, 8'h7f);
    step(1, 0, 0, 0, 8'h7f);
    step(0, 1, 0, 1, 8'h80);
    step(0, 0, 0, 0, 8'h80);
    step(0, 1, 0, 0, 8'h80);

    // seeded random traffic with extreme loads
    for (int i = 0; i < 4000; i++) begin
      bit u, d, c, l;
      logic [W-1:0] p;
      u = $urandom_range(0, 1);
      d = $urandom_range(0, 2) == 0;
      c = $urandom_range(0, 40) == 0;
      l = $urandom_range(0, 25) == 0;
      if ($urandom_range(0, 3) == 0) p = extremes[$urandom_range(0, 3)];
      else p = W'($urandom);
      step(u, d, c, l, p);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule